// File: doc/BRIEF.md
# Telephone Line Status Detector

This block watches two active-low, opto-isolated indications coming from a telephone line interface. One is the ring indication and the other the loop-current indication of an extension handset. It turns them into clean flags for a host processor. The ringing voltage arrives half-wave rectified. While a burst lasts, the ring input therefore toggles at the ringing frequency and never holds a steady level. For this reason ring is qualified on sustained pulse activity. Loop current is a level, so it is qualified on an unbroken hold time.

Both raw inputs first pass through a two-flop synchronizer. All timing runs on an external 1 ms tick enable, so every threshold is counted in milliseconds whatever the system clock is. The host sets the pulse count, the pulse spacing window, the quiet time that ends a burst and the hook hold time. It reads a ring-burst counter and clears it with a strobe. The suggested settings are 4 pulses, a 100 ms window, 200 ms of quiet and a 50 ms hold.

Top module: `line_status_detect`

## Requirements
- R1: While reset is applied, and for the two clock edges after it is released, ring_present, ring_start, burst_count, ext_off_hook and hook_change are all 0.
- R2: A raw input change passes two synchronizer flops. A falling ring edge that completes qualification therefore raises ring_present on the third rising clock edge after the raw input goes low.
- R3: A high-to-low transition of the synchronized ring input is one pulse. The pulse extends the current run if fewer than cfg_pulse_win ticks have passed since the previous pulse. Otherwise the run restarts at 1. The run saturates at 15.
- R4: ring_present rises on the pulse that brings the run to cfg_ring_pulses. A setting of 0 behaves as 1.
- R5: Isolated chatter glitches, or pulse runs shorter than cfg_ring_pulses, never raise ring_present.
- R6: ring_present falls on the tick that brings the number of ticks since the last pulse to cfg_ring_quiet. That count saturates at 511.
- R7: ring_start is high for exactly one cycle, and only in the cycle where ring_present first reads 1.
- R8: burst_count rises by one together with each ring_start and saturates at 255. burst_clr forces it to 0 on the next edge and takes priority over an increment in the same cycle.
- R9: ext_off_hook goes to 1 on the tick that completes cfg_hook_hold ticks during which the synchronized loop input reads low without interruption. Any high sample restarts the count.
- R10: ext_off_hook returns to 0 under the same rule, with the synchronized loop input held high.
- R11: hook_change is a one-cycle pulse in the first cycle that ext_off_hook reads its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1ms | input | 1 | One-cycle enable once per millisecond |
| ring_n_in | input | 1 | Raw ring indication, low while ringing voltage is present |
| loop_n_in | input | 1 | Raw loop-current indication, low while an extension is off hook |
| cfg_ring_pulses | input | 4 | Pulses needed to declare ringing |
| cfg_pulse_win | input | 8 | Maximum pulse spacing in ticks |
| cfg_ring_quiet | input | 9 | Pulse-free ticks that end a burst |
| cfg_hook_hold | input | 8 | Hold time in ticks for hook state changes |
| burst_clr | input | 1 | Clears the ring-burst counter |
| ring_present | output | 1 | Qualified ringing flag |
| ring_start | output | 1 | One-cycle pulse at the start of each burst |
| burst_count | output | 8 | Number of bursts since the last clear |
| ext_off_hook | output | 1 | Qualified extension off-hook flag |
| hook_change | output | 1 | One-cycle pulse on each hook state change |

## Verification
A pulse or loop transition at a raw input reaches the decision logic after two synchronizer edges. The ring flag, ring_start and burst_count then update on the third edge after the raw change. Quiet-time release and hook changes happen on the edge that samples the qualifying tick. The bench drives its inputs on falling clock edges. A behavioural model steps on every rising edge and is compared with all outputs on the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks add the three-edge latency on ring_present, the effect of chatter, slow pulse trains and bouncing loop current, and a clear held across a whole burst.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  // idle level of both opto inputs (no ringing, no loop current)
  localparam logic LINE_IDLE = 1'b1;

  typedef enum logic {
    HOOK_ON  = 1'b0,
    HOOK_OFF = 1'b1
  } hook_e;
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int   W       = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        stab_q <= RST_VAL;
      end else begin
        meta_q <= d_in[i];
        stab_q <= meta_q;
      end
    end
    assign d_out[i] = stab_q;
  end
endmodule

// File: rtl/lsd_ring_qual.sv
module lsd_ring_qual
  import lsd_pkg::*;
#(
  parameter int RUN_W = 4,
  parameter int WIN_W = 8,
  parameter int GAP_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ring_s,
  input  logic [RUN_W-1:0] cfg_need,
  input  logic [WIN_W-1:0] cfg_win,
  input  logic [GAP_W-1:0] cfg_quiet,
  output logic             present,
  output logic             start,
  output logic             rise_next
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic             prev_q;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             pres_q, pres_d;
  logic             start_q, start_d;
  logic             pulse;
  logic [RUN_W-1:0] need;
  logic [GAP_W-1:0] win_ext;

  assign pulse   = prev_q & ~ring_s;
  assign need    = (cfg_need == '0) ? RUN_W'(1) : cfg_need;
  assign win_ext = GAP_W'(cfg_win);

  always_comb begin
    gap_d   = gap_q;
    run_d   = run_q;
    pres_d  = pres_q;
    start_d = 1'b0;
    if (pulse) begin
      gap_d = '0;
      if (gap_q < win_ext) begin
        run_d = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
      end else begin
        run_d = RUN_W'(1);
      end
      if (!pres_q && (run_d >= need)) begin
        pres_d  = 1'b1;
        start_d = 1'b1;
      end
    end else if (tick) begin
      gap_d = (gap_q == GAP_MAX) ? gap_q : gap_q + GAP_W'(1);
      if (pres_q && (gap_d >= cfg_quiet)) begin
        pres_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= LINE_IDLE;
      gap_q   <= GAP_MAX;
      run_q   <= '0;
      pres_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      prev_q  <= ring_s;
      gap_q   <= gap_d;
      run_q   <= run_d;
      pres_q  <= pres_d;
      start_q <= start_d;
    end
  end

  assign present   = pres_q;
  assign start     = start_q;
  assign rise_next = start_d;

  // R4
  rise_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres_q) |-> $past(pulse));
  // R6
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pres_q) |-> $past(tick));
  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
endmodule

// File: rtl/lsd_hook_qual.sv
module lsd_hook_qual
  import lsd_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              loop_s,
  input  logic [HOLD_W-1:0] cfg_hold,
  output logic              off_hook,
  output logic              change
);
  hook_e             state_q, state_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              chg_q, chg_d;
  hook_e             seen;
  logic              differs;
  logic [HOLD_W:0]   cnt_inc;

  assign seen    = loop_s ? HOOK_ON : HOOK_OFF;
  assign differs = (seen != state_q);
  assign cnt_inc = {1'b0, cnt_q} + (HOLD_W+1)'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    chg_d   = 1'b0;
    if (!differs) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, cfg_hold}) begin
        state_d = seen;
        cnt_d   = '0;
        chg_d   = 1'b1;
      end else begin
        cnt_d = cnt_inc[HOLD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HOOK_ON;
      cnt_q   <= '0;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      chg_q   <= chg_d;
    end
  end

  assign off_hook = (state_q == HOOK_OFF);
  assign change   = chg_q;

  // R11
  chg_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (state_q != $past(state_q)));
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_q |-> $stable(state_q));
  // R10
  flip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> $past(tick));
endmodule

// File: rtl/lsd_burst_cnt.sv
module lsd_burst_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cnt_q == '0));
  // R8
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inc) && !$past(clr) && ($past(cnt_q) != CNT_MAX))
      |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/line_status_detect.sv
module line_status_detect
  import lsd_pkg::*;
#(
  parameter int RUN_W  = 4,
  parameter int WIN_W  = 8,
  parameter int GAP_W  = 9,
  parameter int HOLD_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1ms,
  input  logic              ring_n_in,
  input  logic              loop_n_in,
  input  logic [RUN_W-1:0]  cfg_ring_pulses,
  input  logic [WIN_W-1:0]  cfg_pulse_win,
  input  logic [GAP_W-1:0]  cfg_ring_quiet,
  input  logic [HOLD_W-1:0] cfg_hook_hold,
  input  logic              burst_clr,
  output logic              ring_present,
  output logic              ring_start,
  output logic [CNT_W-1:0]  burst_count,
  output logic              ext_off_hook,
  output logic              hook_change
);
  localparam int NUM_IN = 2;
  localparam int IDX_RING = 1;
  localparam int IDX_LOOP = 0;

  logic              rst_meta_q, rst_core_n;
  logic [NUM_IN-1:0] raw_vec, sync_vec;
  logic              rise_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  assign raw_vec[IDX_RING] = ring_n_in;
  assign raw_vec[IDX_LOOP] = loop_n_in;

  lsd_sync #(.W(NUM_IN), .RST_VAL(LINE_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_in  (raw_vec),
    .d_out (sync_vec)
  );

  lsd_ring_qual #(.RUN_W(RUN_W), .WIN_W(WIN_W), .GAP_W(GAP_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick_1ms),
    .ring_s    (sync_vec[IDX_RING]),
    .cfg_need  (cfg_ring_pulses),
    .cfg_win   (cfg_pulse_win),
    .cfg_quiet (cfg_ring_quiet),
    .present   (ring_present),
    .start     (ring_start),
    .rise_next (rise_next)
  );

  lsd_burst_cnt #(.CNT_W(CNT_W)) u_bursts (
    .clk   (clk),
    .rst_n (rst_core_n),
    .inc   (rise_next),
    .clr   (burst_clr),
    .count (burst_count)
  );

  lsd_hook_qual #(.HOLD_W(HOLD_W)) u_hook (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick_1ms),
    .loop_s   (sync_vec[IDX_LOOP]),
    .cfg_hold (cfg_hook_hold),
    .off_hook (ext_off_hook),
    .change   (hook_change)
  );

  // R7
  start_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ring_start |-> (ring_present && $rose(ring_present)));
  // R11
  change_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    hook_change |-> (ext_off_hook != $past(ext_off_hook)));
endmodule

// File: tb/tb_line_status_detect.sv
module tb_line_status_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic       ring_n_in = 1'b1;
  logic       loop_n_in = 1'b1;
  logic [3:0] cfg_ring_pulses = 4'd4;
  logic [7:0] cfg_pulse_win = 8'd100;
  logic [8:0] cfg_ring_quiet = 9'd200;
  logic [7:0] cfg_hook_hold = 8'd50;
  logic       burst_clr = 1'b0;
  logic       ring_present, ring_start, ext_off_hook, hook_change;
  logic [7:0] burst_count;

  localparam int TDIV = 8;

  int tests = 0;
  int fails = 0;
  int starts_seen = 0;
  int div = 0;

  always #2 clk = ~clk;

  line_status_detect dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
    .ring_n_in(ring_n_in), .loop_n_in(loop_n_in),
    .cfg_ring_pulses(cfg_ring_pulses), .cfg_pulse_win(cfg_pulse_win),
    .cfg_ring_quiet(cfg_ring_quiet), .cfg_hook_hold(cfg_hook_hold),
    .burst_clr(burst_clr), .ring_present(ring_present), .ring_start(ring_start),
    .burst_count(burst_count), .ext_off_hook(ext_off_hook), .hook_change(hook_change)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // millisecond tick generator
  always @(negedge clk) begin
    if (!rst_n) begin
      div = 0;
      tick_1ms <= 1'b0;
    end else begin
      div = (div + 1) % TDIV;
      tick_1ms <= (div == 0);
    end
  end

  // behavioural reference model
  bit rq[$];
  bit lq[$];
  int rel = 0;
  int m_gap, m_run, m_cnt, m_hcnt, nr, need;
  bit m_pres, m_start, m_off, m_chg, pulse_m, lsync;

  task automatic m_reset();
    rq = '{1'b1, 1'b1, 1'b1};
    lq = '{1'b1, 1'b1};
    m_gap = 511; m_run = 0; m_cnt = 0; m_hcnt = 0;
    m_pres = 0; m_start = 0; m_off = 0; m_chg = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0;
      m_reset();
    end else if (rel < 2) begin
      rel++;
      m_reset();
    end else begin
      pulse_m = (rq[1] == 1'b0) && (rq[2] == 1'b1);
      lsync = lq[1];
      m_start = 0;
      need = (cfg_ring_pulses == 0) ? 1 : int'(cfg_ring_pulses);
      if (pulse_m) begin
        nr = (m_gap < int'(cfg_pulse_win)) ? m_run + 1 : 1;
        if (nr > 15) nr = 15;
        m_run = nr;
        m_gap = 0;
        if (!m_pres && nr >= need) begin m_pres = 1; m_start = 1; end
      end else if (tick_1ms) begin
        if (m_gap < 511) m_gap++;
        if (m_pres && m_gap >= int'(cfg_ring_quiet)) m_pres = 0;
      end
      if (burst_clr) m_cnt = 0;
      else if (m_start && m_cnt < 255) m_cnt++;
      m_chg = 0;
      if ((lsync == 1'b0) == m_off) m_hcnt = 0;
      else if (tick_1ms) begin
        if (m_hcnt + 1 >= int'(cfg_hook_hold)) begin
          m_off = !m_off; m_hcnt = 0; m_chg = 1;
        end else m_hcnt++;
      end
      rq.push_front(ring_n_in); void'(rq.pop_back());
      lq.push_front(loop_n_in); void'(lq.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 R6 ring_present", ring_present, m_pres);
      chk("R7 ring_start", ring_start, m_start);
      chk("R8 burst_count", burst_count, m_cnt);
      chk("R9 R10 ext_off_hook", ext_off_hook, m_off);
      chk("R11 hook_change", hook_change, m_chg);
      if (ring_start) starts_seen++;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic ring_train(input int n, input int period, input int low);
    for (int i = 0; i < n; i++) begin
      ring_n_in <= 1'b0;
      wait_ticks(low);
      ring_n_in <= 1'b1;
      wait_ticks(period - low);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 ring_present in reset", ring_present, 0);
    chk("R1 burst_count in reset", burst_count, 0);
    chk("R1 ext_off_hook in reset", ext_off_hook, 0);
    rst_n <= 1'b1;
    @(negedge clk);
    chk("R1 ring_start after release", ring_start, 0);
    chk("R1 hook_change after release", hook_change, 0);
    wait_ticks(5);

    // R5: chatter glitches
    for (int g = 0; g < 2; g++) begin
      ring_n_in <= 1'b0; @(negedge clk);
      ring_n_in <= 1'b1; repeat (6) @(negedge clk);
    end
    wait_ticks(20);
    chk("R5 chatter ignored", ring_present, 0);

    // R4 R6: normal burst
    ring_train(8, 40, 20);
    chk("R4 burst declared", ring_present, 1);
    chk("R8 first burst counted", burst_count, 1);
    wait_ticks(250);
    chk("R6 released after quiet", ring_present, 0);

    // R3: pulses spaced beyond the window
    ring_train(5, 120, 40);
    chk("R3 slow pulses not ringing", ring_present, 0);
    wait_ticks(250);

    // R2 R4: single pulse threshold, latency of three edges
    cfg_ring_pulses <= 4'd0;
    @(negedge clk);
    ring_n_in <= 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R2 not yet after two edges", ring_present, 0);
    @(posedge clk); #1;
    chk("R2 R4 set on third edge", ring_present, 1);
    @(negedge clk);
    wait_ticks(10);
    ring_n_in <= 1'b1;
    wait_ticks(250);
    chk("R8 second burst counted", burst_count, 2);
    cfg_ring_pulses <= 4'd4;

    // R8: clear held across a burst wins over increment
    @(negedge clk);
    burst_clr <= 1'b1;
    ring_train(6, 40, 20);
    burst_clr <= 1'b0;
    @(negedge clk);
    chk("R8 clear priority", burst_count, 0);
    wait_ticks(250);
    chk("R7 one start per burst", starts_seen, 3);

    // R9 R10: loop current with bounces
    loop_n_in <= 1'b0; wait_ticks(30);
    loop_n_in <= 1'b1; wait_ticks(5);
    chk("R9 short loop ignored", ext_off_hook, 0);
    loop_n_in <= 1'b0; wait_ticks(60);
    chk("R9 off hook declared", ext_off_hook, 1);
    loop_n_in <= 1'b1; wait_ticks(20);
    loop_n_in <= 1'b0; wait_ticks(5);
    chk("R10 short release ignored", ext_off_hook, 1);
    loop_n_in <= 1'b1; wait_ticks(60);
    chk("R10 on hook restored", ext_off_hook, 0);

    // R11: short hold setting
    cfg_hook_hold <= 8'd5;
    loop_n_in <= 1'b0; wait_ticks(8);
    chk("R11 quick off hook", ext_off_hook, 1);
    loop_n_in <= 1'b1; wait_ticks(8);
    chk("R11 quick on hook", ext_off_hook, 0);

    summary();
  end
endmodule